// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns every bus cycle into a set of active-low select strobes, one per memory region. Each region has a base register and a mask register, both written and read through a small register port. A region's strobe goes low when the address bits from 31 down to 16 that the mask leaves in play equal the programmed base, and when the cycle's type is not barred by that region's permission bits. Select 0 starts out as a catch-all boot strobe that fires on any valid cycle. The first write to its mask register ends the catch-all mode, and select 0 then decodes like the others.

Cycles driven by an outside bus master use a reduced address. The top four compared bits are treated as zero. The next four take the address pin only where the pin multiplexer has routed that pin as an address line, and zero elsewhere. The remaining eight bits come straight from the bus.

Top module: `csel_decoder`

## Requirements
- R1: Register address `{select index, kind}` picks a register, with kind 0 for base and kind 1 for mask. A base write stores data bits 31:16, and a base read returns them with bits 15:0 as zero.
- R2: A mask read returns the stored mask in bits 31:16 and the permission bits in 3:0. Bit 4 reads back only on the CPU-gated select (select 1) and is zero on all others. Every other bit reads zero.
- R3: After reset, the mask register of select 0 reads zero and every strobe is high.
- R4: From reset until the first write to select 0's mask, select 0 goes low for every valid cycle, whatever the address or type.
- R5: A write to select 0's mask register ends the catch-all mode for good. Writes to other registers leave it on.
- R6: For a processor cycle, select i hits when `((addr[31:16] ^ base_i) & ~mask_i) == 0`.
- R7: A mask bit set to 1 removes that address bit from the comparison, and unmasked bits still count.
- R8: The permission bits are bit 0 for user data, bit 1 for user code, bit 2 for supervisor data and bit 3 for supervisor code. A set bit blocks its select for that cycle type (`bus_super`, `bus_data`).
- R9: On select 1, mask bit 4 set blocks the select during CPU-space cycles. Other selects are not affected by CPU-space cycles.
- R10: For an outside-master cycle (`bus_ext`=1), compared bits 31:28 are taken as zero.
- R11: For an outside-master cycle, compared bit 24+k is `bus_addr[24+k]` when `pin_addr_en[k]`=1, and zero when it is 0.
- R12: For an outside-master cycle, compared bits 23:16 are the bus address bits 23:16.
- R13: Strobes are registered and change one clock after the cycle is presented. While `bus_valid` is 0, all strobes are high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | SEL_W+1 | Register select: `{index, kind}` |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational from reg_addr) |
| bus_valid | input | 1 | A bus cycle is in progress |
| bus_addr | input | ADDR_W | Cycle address |
| bus_super | input | 1 | 1 = supervisor, 0 = user |
| bus_data | input | 1 | 1 = data access, 0 = code fetch |
| bus_cpu_space | input | 1 | CPU-space cycle (including interrupt acknowledge) |
| bus_ext | input | 1 | Cycle driven by an outside master |
| pin_addr_en | input | MUX_W | Per multiplexed pin: 1 = routed as address line |
| cs_n | output | NUM_SEL | Active-low select strobes |

## Verification
The bench builds the decoder with its defaults: eight selects, a 32-bit address, comparison from bit 16, a four-pin multiplexed group at bits 27:24, and the CPU-space gate on select 1. With these values the bench can place one distinct region in each select. This lets it show overlapping hits during the boot phase, both mux pin states for each lane of the outside-master path, and that the gate bit exists on select 1 and is absent on a neighbour.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int PERM_W  = 4;
    localparam int CPU_BIT = 4;

    typedef enum logic {
        KIND_BASE = 1'b0,
        KIND_MASK = 1'b1
    } reg_kind_e;

    // Permission index: {supervisor, code}; bit0 UD, bit1 UC, bit2 SD, bit3 SC
    function automatic logic [1:0] perm_index(input logic supv, input logic data);
        return {supv, ~data};
    endfunction
endpackage

// File: rtl/csel_regs.sv
module csel_regs
    import csel_pkg::*;
#(
    parameter int NUM_SEL      = 8,
    parameter int ADDR_W       = 32,
    parameter int CMP_LSB      = 16,
    parameter int CPU_GATE_SEL = 1,
    localparam int SEL_W = $clog2(NUM_SEL),
    localparam int CMP_W = ADDR_W - CMP_LSB
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SEL_W:0]                    wr_addr,
    input  logic [ADDR_W-1:0]                 wr_data,
    input  logic [SEL_W:0]                    rd_addr,
    output logic [ADDR_W-1:0]                 rd_data,
    output logic [NUM_SEL-1:0][CMP_W-1:0]     base_o,
    output logic [NUM_SEL-1:0][CMP_W-1:0]     mask_o,
    output logic [NUM_SEL-1:0][PERM_W-1:0]    perm_o,
    output logic [NUM_SEL-1:0]                cpu_blk_o,
    output logic                              boot_o
);
    logic [SEL_W-1:0] wr_sel, rd_sel;
    reg_kind_e        wr_kind, rd_kind;
    logic             wdata_unused;

    assign wr_sel       = wr_addr[SEL_W:1];
    assign wr_kind      = reg_kind_e'(wr_addr[0]);
    assign rd_sel       = rd_addr[SEL_W:1];
    assign rd_kind      = reg_kind_e'(rd_addr[0]);
    assign wdata_unused = ^wr_data[CMP_LSB-1:CPU_BIT+1];

    // Catch-all boot mode of select 0
    typedef struct packed {
        logic boot;
    } ctl_t;
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && wr_sel == '0 && wr_kind == KIND_MASK)
            ctl_d.boot = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{boot: 1'b1};
        else        ctl_q <= ctl_d;
    end

    assign boot_o = ctl_q.boot;

    // Per-select storage
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        typedef struct packed {
            logic [CMP_W-1:0]  base;
            logic [CMP_W-1:0]  mask;
            logic [PERM_W-1:0] perm;
            logic              cpu;
        } ent_t;
        ent_t ent_d, ent_q;
        logic wr_hit;

        assign wr_hit = wr_en && (wr_sel == SEL_W'(g));

        always_comb begin
            ent_d = ent_q;
            if (wr_hit) begin
                if (wr_kind == KIND_BASE) begin
                    ent_d.base = wr_data[ADDR_W-1:CMP_LSB];
                end else begin
                    ent_d.mask = wr_data[ADDR_W-1:CMP_LSB];
                    ent_d.perm = wr_data[PERM_W-1:0];
                    ent_d.cpu  = (g == CPU_GATE_SEL) ? wr_data[CPU_BIT] : 1'b0;
                end
            end
        end

        if (g == 0) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q <= '0;
                else        ent_q <= ent_d;
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                ent_q <= ent_d;
            end
        end

        assign base_o[g]    = ent_q.base;
        assign mask_o[g]    = ent_q.mask;
        assign perm_o[g]    = ent_q.perm;
        assign cpu_blk_o[g] = (g == CPU_GATE_SEL) ? ent_q.cpu : 1'b0;
    end

    // Read-back multiplexer
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                if (rd_kind == KIND_BASE)
                    rd_data = {base_o[i], {CMP_LSB{1'b0}}};
                else
                    rd_data = {mask_o[i], {(CMP_LSB-PERM_W-1){1'b0}},
                               cpu_blk_o[i], perm_o[i]};
            end
        end
    end
endmodule

// File: rtl/csel_match.sv
module csel_match
    import csel_pkg::*;
#(
    parameter int CMP_W = 16
) (
    input  logic [CMP_W-1:0]  cmp_addr,
    input  logic [CMP_W-1:0]  base,
    input  logic [CMP_W-1:0]  mask,
    input  logic [PERM_W-1:0] perm,
    input  logic              cpu_blk,
    input  logic              supv,
    input  logic              data,
    input  logic              cpu_space,
    output logic              grant
);
    logic region_hit;
    logic type_denied;

    always_comb begin
        region_hit  = ((cmp_addr ^ base) & ~mask) == '0;
        type_denied = perm[perm_index(supv, data)] || (cpu_blk && cpu_space);
        grant       = region_hit && !type_denied;
    end
endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
    import csel_pkg::*;
#(
    parameter int NUM_SEL      = 8,
    parameter int ADDR_W       = 32,
    parameter int CMP_LSB      = 16,
    parameter int MUX_LSB      = 24,
    parameter int MUX_W        = 4,
    parameter int CPU_GATE_SEL = 1,
    localparam int SEL_W   = $clog2(NUM_SEL),
    localparam int CMP_W   = ADDR_W - CMP_LSB,
    localparam int MUX_OFF = MUX_LSB - CMP_LSB,
    localparam int MUX_TOP = MUX_OFF + MUX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [SEL_W:0]     reg_addr,
    input  logic [ADDR_W-1:0]  reg_wdata,
    output logic [ADDR_W-1:0]  reg_rdata,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_super,
    input  logic               bus_data,
    input  logic               bus_cpu_space,
    input  logic               bus_ext,
    input  logic [MUX_W-1:0]   pin_addr_en,
    output logic [NUM_SEL-1:0] cs_n
);
    logic [NUM_SEL-1:0][CMP_W-1:0]  base_v, mask_v;
    logic [NUM_SEL-1:0][PERM_W-1:0] perm_v;
    logic [NUM_SEL-1:0]             cpu_blk;
    logic [NUM_SEL-1:0]             grant;
    logic                           boot;
    logic [CMP_W-1:0]               ext_hi, cmp_hi;
    logic                           addr_unused;

    assign addr_unused = ^bus_addr[CMP_LSB-1:0];

    csel_regs #(
        .NUM_SEL      (NUM_SEL),
        .ADDR_W       (ADDR_W),
        .CMP_LSB      (CMP_LSB),
        .CPU_GATE_SEL (CPU_GATE_SEL)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .rd_addr   (reg_addr),
        .rd_data   (reg_rdata),
        .base_o    (base_v),
        .mask_o    (mask_v),
        .perm_o    (perm_v),
        .cpu_blk_o (cpu_blk),
        .boot_o    (boot)
    );

    // Reduced comparison address for outside-master cycles
    always_comb begin
        ext_hi                  = '0;
        ext_hi[MUX_OFF-1:0]     = bus_addr[MUX_LSB-1:CMP_LSB];
        ext_hi[MUX_TOP-1:MUX_OFF] = bus_addr[MUX_LSB+MUX_W-1:MUX_LSB] & pin_addr_en;
        cmp_hi = bus_ext ? ext_hi : bus_addr[ADDR_W-1:CMP_LSB];
    end

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_match
        csel_match #(.CMP_W(CMP_W)) u_match (
            .cmp_addr  (cmp_hi),
            .base      (base_v[g]),
            .mask      (mask_v[g]),
            .perm      (perm_v[g]),
            .cpu_blk   (cpu_blk[g]),
            .supv      (bus_super),
            .data      (bus_data),
            .cpu_space (bus_cpu_space),
            .grant     (grant[g])
        );
    end

    // Registered strobe stage
    typedef struct packed {
        logic [NUM_SEL-1:0] cs_n;
    } out_t;
    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.cs_n = ~({NUM_SEL{bus_valid}} &
                       (grant | {{(NUM_SEL-1){1'b0}}, boot}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{cs_n: '1};
        else        out_q <= out_d;
    end

    assign cs_n = out_q.cs_n;
endmodule

// File: rtl/csel_decoder_chk.sv
module csel_decoder_chk #(
    parameter int NUM_SEL      = 8,
    parameter int ADDR_W       = 32,
    parameter int CMP_LSB      = 16,
    parameter int CPU_GATE_SEL = 1,
    localparam int SEL_W = $clog2(NUM_SEL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [SEL_W:0]     reg_addr,
    input logic [ADDR_W-1:0]  reg_rdata,
    input logic               bus_valid,
    input logic               bus_cpu_space,
    input logic [NUM_SEL-1:0] cs_n,
    input logic               boot,
    input logic [NUM_SEL-1:0] cpu_blk
);
    AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (&cs_n)); // R13

    AST_BOOT_CATCH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (boot && bus_valid) |=> !cs_n[0]); // R4

    AST_BOOT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == {{SEL_W{1'b0}}, 1'b1}) |=> !boot); // R5

    AST_BOOT_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !boot |=> !boot); // R5

    AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr[0] |-> (reg_rdata[CMP_LSB-1:0] == '0)); // R1

    AST_CPU_SPACE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cpu_space && cpu_blk[CPU_GATE_SEL] &&
         (CPU_GATE_SEL != 0 || !boot)) |=> cs_n[CPU_GATE_SEL]); // R9
endmodule

bind csel_decoder csel_decoder_chk #(
    .NUM_SEL      (NUM_SEL),
    .ADDR_W       (ADDR_W),
    .CMP_LSB      (CMP_LSB),
    .CPU_GATE_SEL (CPU_GATE_SEL)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .bus_valid     (bus_valid),
    .bus_cpu_space (bus_cpu_space),
    .cs_n          (cs_n),
    .boot          (boot),
    .cpu_blk       (cpu_blk)
);

// File: tb/csel_decoder_test.sv
module csel_decoder_test;
    localparam int SEL_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_super = 1'b0;
    logic        bus_data = 1'b0;
    logic        bus_cpu_space = 1'b0;
    logic        bus_ext = 1'b0;
    logic [3:0]  pin_addr_en = '0;
    logic [7:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    csel_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_super(bus_super), .bus_data(bus_data),
        .bus_cpu_space(bus_cpu_space), .bus_ext(bus_ext),
        .pin_addr_en(pin_addr_en), .cs_n(cs_n)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input bit kind, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = {SEL_W'(sel), kind};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int sel, input bit kind, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = {SEL_W'(sel), kind};
        #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic access(input logic [31:0] a, input bit sv, input bit dt, input bit cpu,
                          input bit ext, input logic [3:0] pin, input logic [7:0] exp,
                          input string tag);
        @(negedge clk);
        bus_addr = a; bus_super = sv; bus_data = dt; bus_cpu_space = cpu;
        bus_ext = ext; pin_addr_en = pin; bus_valid = 1'b1;
        @(negedge clk);
        chk({24'h0, cs_n}, {24'h0, exp}, tag);
        bus_valid = 1'b0; bus_ext = 1'b0; bus_cpu_space = 1'b0; pin_addr_en = '0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk({24'h0, cs_n}, 32'h0000_00FF, "R3 strobes high after reset");
        rd(0, 1'b1, 32'h0, "R3 mask0 cleared by reset");
    endtask

    task automatic t_setup_and_boot;
        for (int i = 0; i < 8; i++) wr(i, 1'b0, 32'(i) << 20);
        for (int i = 1; i < 8; i++) wr(i, 1'b1, 32'h0);
        access(32'hFFFF_1234, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'hFE, "R4 catch-all any address");
        access(32'h0030_0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'hF6, "R4 R6 boot plus region 3");
    endtask

    task automatic t_regs;
        wr(5, 1'b0, 32'h1234_5678);
        rd(5, 1'b0, 32'h1234_0000, "R1 base readback low half zero");
        wr(5, 1'b0, 32'h0050_0000);
        rd(3, 1'b0, 32'h0030_0000, "R1 base3 readback");
        wr(2, 1'b1, 32'hFFFF_FFFF);
        rd(2, 1'b1, 32'hFFFF_000F, "R2 mask readback no gate bit");
        wr(1, 1'b1, 32'hFFFF_FFFF);
        rd(1, 1'b1, 32'hFFFF_001F, "R2 mask1 readback with gate bit");
        wr(1, 1'b1, 32'h0);
        wr(2, 1'b1, 32'h0);
        access(32'hFFFF_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFE, "R5 other writes keep catch-all");
    endtask

    task automatic t_cancel;
        wr(0, 1'b1, 32'h0);
        rd(0, 1'b1, 32'h0, "R5 mask0 after write");
        access(32'hFFFF_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFF, "R5 catch-all ended");
        access(32'h0000_5555, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'hFE, "R6 select0 normal decode");
        access(32'h0070_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'h7F, "R6 region 7");
    endtask

    task automatic t_maskbits;
        wr(4, 1'b1, 32'h000F_0000);
        access(32'h0043_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hEF, "R7 masked bits ignored");
        access(32'h0053_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFF, "R7 unmasked bit 20 differs");
        access(32'h0143_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFF, "R7 unmasked bit 24 differs");
        wr(4, 1'b1, 32'h0);
    endtask

    task automatic t_perm;
        wr(6, 1'b1, 32'h4);
        access(32'h0060_0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFF, "R8 SD blocks supv data");
        access(32'h0060_0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'hBF, "R8 SD leaves supv code");
        access(32'h0060_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hBF, "R8 SD leaves user data");
        wr(6, 1'b1, 32'h1);
        access(32'h0060_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFF, "R8 UD blocks user data");
        access(32'h0060_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'hBF, "R8 UD leaves user code");
        wr(6, 1'b1, 32'h2);
        access(32'h0060_0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 8'hFF, "R8 UC blocks user code");
        wr(6, 1'b1, 32'h8);
        access(32'h0060_0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 8'hFF, "R8 SC blocks supv code");
        wr(6, 1'b1, 32'h0);
    endtask

    task automatic t_cpu;
        wr(1, 1'b1, 32'h10);
        access(32'h0010_0000, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'hFF, "R9 gate blocks cpu space");
        access(32'h0010_0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFD, "R9 gate passes normal cycle");
        access(32'h0030_0000, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'hF7, "R9 other select in cpu space");
        wr(2, 1'b1, 32'h1F);
        rd(2, 1'b1, 32'h0000_000F, "R2 R9 gate bit absent on select 2");
        wr(1, 1'b1, 32'h0);
        wr(2, 1'b1, 32'h0);
    endtask

    task automatic t_ext;
        access(32'hF030_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 8'hF7, "R10 top bits forced zero");
        access(32'hF030_0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 8'hFF, "R10 processor cycle uses top bits");
        wr(2, 1'b0, 32'h0520_0000);
        access(32'h0520_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 8'hFB, "R11 all pins as address");
        access(32'h0520_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 8'hFF, "R11 no pins as address");
        access(32'h0520_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'h5, 8'hFB, "R11 pins 0 and 2");
        access(32'h0520_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'h4, 8'hFF, "R11 pin 0 disabled");
        access(32'h0031_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0, 8'hFF, "R12 low bits compared");
        access(32'h0070_0000, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 8'h7F, "R12 low bits match");
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_addr = 32'h0030_0000; bus_super = 1'b0; bus_data = 1'b1; bus_valid = 1'b0;
        @(negedge clk);
        chk({24'h0, cs_n}, 32'hFF, "R13 idle keeps strobes high");
        bus_valid = 1'b1;
        #1;
        chk({24'h0, cs_n}, 32'hFF, "R13 no change before clock");
        @(negedge clk);
        chk({24'h0, cs_n}, 32'hF7, "R13 strobe one clock later");
        bus_valid = 1'b0;
        @(negedge clk);
        chk({24'h0, cs_n}, 32'hFF, "R13 release after valid drops");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup_and_boot();
        t_regs();
        t_cancel();
        t_maskbits();
        t_perm();
        t_cpu();
        t_ext();
        t_timing();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule